// File: doc/BRIEF.md
# Serial Result Port with Stall Timeout

This block is the serial front end of a sensor converter. A host drives a four-wire serial bus: an active-low select, a serial clock, a data input and a data output. Command and configuration bytes arrive on the data input and are handed on a byte at a time. Conversion results leave on the data output, most significant bit first, as 16-bit two's-complement words spread over two bytes. The block also drives an active-low data-ready line. While the data output is not busy with a word, it carries the same ready indication.

The serial lines are sampled in the modulator clock domain. A stall timer counts modulator clock periods while a byte is only partly received. When the count expires, the partial byte is thrown away and framing starts over. The limit is 13955 periods in the normal and duty-cycled modes and 27910 periods in turbo mode. A result register is copied into the output shifter only when a word starts, so a result that arrives during a read never mixes with the word being sent.

Top module: `spi_result_port`

## Requirements
- R1: After synchronous reset, with select high, `dout_oe` is 0, `drdy_n` is 1 and `rx_valid` is 0.
- R2: `dout_oe` is 1 exactly while `cs_n` is 0, so the data output floats whenever the bus is deselected.
- R3: `din` is captured at each falling edge of `sclk` while selected. After 8 falling edges, `rx_byte` holds the captured bits, with the first bit in bit 7, and `rx_valid` is high for one cycle.
- R4: Any number of bytes can be transferred in one select window. Framing restarts every 8 falling edges.
- R5: A result word is sent as 16 bits, most significant first. Each bit appears after a rising edge of `sclk`, so the first byte carries bits 15..8 and the second byte carries bits 7..0. A third byte in the same window starts the word again.
- R6: While selected, and before the first rising edge of a word or after its 16th falling edge, `dout` equals `drdy_n`.
- R7: `drdy_n` goes low in the cycle after a `res_valid` pulse. It returns high at the first rising edge of the next word, unless a new `res_valid` arrives in that same cycle.
- R8: A result that arrives in the middle of a word does not change the rest of that word. It is sent in the next word.
- R9: With `turbo` at 0, a byte that stays partial for 13955 modulator clock periods with no `sclk` edge is discarded. Any shorter pause keeps the partial byte.
- R10: With `turbo` at 1, the discard limit is 27910 periods. A pause longer than 13955 but shorter than 27910 periods keeps the partial byte.
- R11: Raising `cs_n` discards a partial byte and resets the word position.
- R12: The stall timer does not run at a byte boundary. A pause of any length between the two bytes of a word keeps the word position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Bus select, active low, synchronous to `clk` |
| sclk | input | 1 | Serial clock, synchronous to `clk`, idles low |
| din | input | 1 | Serial data in, taken at falling `sclk` |
| dout | output | 1 | Serial data out, or the ready flag when no word is in flight |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |
| drdy_n | output | 1 | Data ready, active low |
| turbo | input | 1 | 1 selects the long stall limit |
| res_valid | input | 1 | One-cycle strobe for a new conversion result |
| res_data | input | 16 | Conversion result, two's complement |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is new |

## Verification
The assertions check on every cycle that the ready line falls after each result strobe, that received-byte strobes last one cycle and never follow a deselected cycle, that a freshly selected bus shows the ready flag on the data output, and that the stall counter stays under its larger limit. Only the bench scenarios can show the bit order of received and sent bytes, word continuity across pauses at a byte boundary, protection of a word from a result that arrives mid-read, and the exact stall limits in both modes. These scenarios pause for just under and just over each limit.

// File: rtl/spi_port_pkg.sv
// Package: shared defaults for the serial result port.
// Assumes: nothing; constants only.
package spi_port_pkg;
    localparam int unsigned DEF_RES_W      = 16;
    localparam int unsigned DEF_FRAME_W    = 8;
    localparam int unsigned DEF_TMO_NORMAL = 13955;
    localparam int unsigned DEF_TMO_TURBO  = 27910;
endpackage

// File: rtl/spi_sclk_edges.sv
// Module: finds rising and falling edges of the serial clock in the clk domain.
// Assumes: sclk is already synchronous to clk and each level lasts at least 2 clk cycles.
module spi_sclk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    // Purpose: remember the previous sclk level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Purpose: report edges only while the bus is selected.
    always_comb begin
        rise = !cs_n && sclk && !sclk_q;
        fall = !cs_n && !sclk && sclk_q;
    end
endmodule

// File: rtl/spi_rx_framer.sv
// Module: shifts in din at falling sclk and delivers whole bytes.
// Assumes: edges come from spi_sclk_edges; abort is a one-cycle pulse.
module spi_rx_framer #(
    parameter int unsigned FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               fall,
    input  logic               din,
    input  logic               abort,
    output logic [FRAME_W-1:0] rx_byte,
    output logic               rx_valid,
    output logic               partial
);
    localparam int unsigned BC_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
    localparam logic [BC_W-1:0] LAST = BC_W'(FRAME_W - 1);

    logic [BC_W-1:0]    bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] next_sh;

    // Purpose: next shift value with the new bit in the LSB.
    always_comb next_sh = {shreg[FRAME_W-2:0], din};

    // Purpose: count bits, assemble bytes, and clear on deselect or stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (cs_n || abort) begin
                bit_cnt <= '0;
            end else if (fall) begin
                shreg <= next_sh;
                if (bit_cnt == LAST) begin
                    rx_byte  <= next_sh;
                    rx_valid <= 1'b1;
                    bit_cnt  <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // Purpose: tell the stall timer that a byte is open.
    always_comb partial = (bit_cnt != '0);
endmodule

// File: rtl/spi_stall_timer.sv
// Module: counts modulator clocks while a byte is partial and no sclk edge occurs;
//         issues an abort pulse when the mode-selected limit is reached.
// Assumes: both limits are at least 2.
module spi_stall_timer #(
    parameter int unsigned TMO_NORMAL = 13955,
    parameter int unsigned TMO_TURBO  = 27910,
    parameter int unsigned CNT_W      = $clog2(((TMO_NORMAL > TMO_TURBO) ? TMO_NORMAL : TMO_TURBO) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rise,
    input  logic             fall,
    input  logic             partial,
    input  logic             turbo,
    output logic             abort,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIM_N = CNT_W'(TMO_NORMAL - 1);
    localparam logic [CNT_W-1:0] LIM_T = CNT_W'(TMO_TURBO - 1);

    logic             run;
    logic [CNT_W-1:0] last_val;

    // Purpose: decide whether the count advances and where it ends.
    always_comb begin
        run      = !cs_n && partial && !rise && !fall;
        last_val = turbo ? LIM_T : LIM_N;
        abort    = run && (cnt == last_val);
    end

    // Purpose: advance, clear, or wrap the stall count.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (!run || abort)   cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_tx_path.sv
// Module: holds the latest result, sends it MSB-first at rising sclk, and drives
//         the ready flag. A word is copied from the holding register only at its first bit.
// Assumes: each word is clocked as RES_W rise/fall pairs.
module spi_tx_path #(
    parameter int unsigned RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rise,
    input  logic             fall,
    input  logic             abort,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    output logic             dout_bit,
    output logic             in_word,
    output logic             drdy_n
);
    localparam int unsigned TC_W = $clog2(RES_W + 1);
    localparam logic [TC_W-1:0] WORD_END = TC_W'(RES_W);

    logic [RES_W-1:0] hold;
    logic [RES_W-1:0] shreg;
    logic [TC_W-1:0]  tx_cnt;
    logic             word_start;

    // Purpose: detect the first rising edge of a word.
    always_comb word_start = rise && (tx_cnt == '0);

    // Purpose: keep the newest result for the next word.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold <= '0;
        else if (res_valid) hold <= res_data;
    end

    // Purpose: step through the word bits and close the word after its last falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt   <= '0;
            shreg    <= '0;
            dout_bit <= 1'b0;
        end else if (cs_n || abort) begin
            tx_cnt <= '0;
        end else if (word_start) begin
            dout_bit <= hold[RES_W-1];
            shreg    <= {hold[RES_W-2:0], 1'b0};
            tx_cnt   <= TC_W'(1);
        end else if (rise && tx_cnt < WORD_END) begin
            dout_bit <= shreg[RES_W-1];
            shreg    <= {shreg[RES_W-2:0], 1'b0};
            tx_cnt   <= tx_cnt + 1'b1;
        end else if (fall && tx_cnt == WORD_END) begin
            tx_cnt <= '0;
        end
    end

    // Purpose: set the ready flag on a new result and clear it when a word starts.
    always_ff @(posedge clk) begin
        if (!rst_n)          drdy_n <= 1'b1;
        else if (res_valid)  drdy_n <= 1'b0;
        else if (word_start) drdy_n <= 1'b1;
    end

    // Purpose: tell the output mux whether a word is in flight.
    always_comb in_word = (tx_cnt != '0);
endmodule

// File: rtl/spi_result_port.sv
// Module: top of the serial result port; ties edge detect, receive framing,
//         stall timer and transmit path together and muxes the data output.
// Assumes: cs_n, sclk and din are synchronous to clk (the modulator clock).
module spi_result_port
    import spi_port_pkg::*;
#(
    parameter int unsigned RES_W      = DEF_RES_W,
    parameter int unsigned FRAME_W    = DEF_FRAME_W,
    parameter int unsigned TMO_NORMAL = DEF_TMO_NORMAL,
    parameter int unsigned TMO_TURBO  = DEF_TMO_TURBO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               din,
    output logic               dout,
    output logic               dout_oe,
    output logic               drdy_n,
    input  logic               turbo,
    input  logic               res_valid,
    input  logic [RES_W-1:0]   res_data,
    output logic [FRAME_W-1:0] rx_byte,
    output logic               rx_valid
);
    localparam int unsigned TMO_MAX = (TMO_NORMAL > TMO_TURBO) ? TMO_NORMAL : TMO_TURBO;
    localparam int unsigned CNT_W   = $clog2(TMO_MAX + 1);

    logic             rise, fall, abort, partial, dout_bit, in_word;
    logic [CNT_W-1:0] tmo_cnt;

    spi_sclk_edges u_edges (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .rise(rise), .fall(fall)
    );

    spi_rx_framer #(.FRAME_W(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fall(fall), .din(din), .abort(abort),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .partial(partial)
    );

    spi_stall_timer #(.TMO_NORMAL(TMO_NORMAL), .TMO_TURBO(TMO_TURBO), .CNT_W(CNT_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(rise), .fall(fall), .partial(partial),
        .turbo(turbo), .abort(abort), .cnt(tmo_cnt)
    );

    spi_tx_path #(.RES_W(RES_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(rise), .fall(fall), .abort(abort),
        .res_valid(res_valid), .res_data(res_data), .dout_bit(dout_bit), .in_word(in_word),
        .drdy_n(drdy_n)
    );

    // Purpose: send word bits during a word and the ready flag otherwise; float when deselected.
    always_comb begin
        dout    = in_word ? dout_bit : drdy_n;
        dout_oe = !cs_n;
    end
endmodule

// File: rtl/spi_result_port_chk.sv
// Module: property checker bound to spi_result_port.
// Assumes: reset is held for at least one clock at start.
module spi_result_port_chk #(
    parameter int unsigned CNT_W   = 15,
    parameter int unsigned TMO_MAX = 27910
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             res_valid,
    input logic             rx_valid,
    input logic             drdy_n,
    input logic             dout,
    input logic [CNT_W-1:0] tmo_cnt
);
    // R7
    drdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !drdy_n);

    // R3
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !rx_valid);

    // R6
    dout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(cs_n)) |-> (dout == drdy_n));

    // R9
    tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_cnt < CNT_W'(TMO_MAX));
endmodule

bind spi_result_port spi_result_port_chk #(.CNT_W(CNT_W), .TMO_MAX(TMO_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .res_valid(res_valid), .rx_valid(rx_valid),
    .drdy_n(drdy_n), .dout(dout), .tmo_cnt(tmo_cnt)
);

// File: tb/test_spi_result_port.sv
module test_spi_result_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0, turbo = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        dout, dout_oe, drdy_n, rx_valid;
    logic [7:0]  rx_byte;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    spi_result_port i_spi_result_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout),
        .dout_oe(dout_oe), .drdy_n(drdy_n), .turbo(turbo), .res_valid(res_valid),
        .res_data(res_data), .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated at each rising clock edge.
    int       m_bits, m_sent, m_idle;
    bit       m_prev, m_dq, m_drdy = 1'b1, m_rxv, m_live;
    bit [7:0] m_rxb, m_rxsh;
    bit [15:0] m_hold;
    bit       m_q[$];

    always @(posedge clk) begin
        bit r, f;
        int old_bits, lim;
        m_live = 1'b1;
        if (!rst_n) begin
            m_prev = 0; m_bits = 0; m_sent = 0; m_idle = 0; m_hold = 0; m_dq = 0;
            m_drdy = 1; m_rxv = 0; m_rxb = 0; m_rxsh = 0; m_q.delete();
        end else begin
            r = !cs_n && sclk && !m_prev;
            f = !cs_n && !sclk && m_prev;
            m_prev = sclk;
            old_bits = m_bits;
            m_rxv = 0;
            lim = turbo ? 27910 : 13955;
            if (cs_n) begin
                m_bits = 0; m_sent = 0; m_idle = 0; m_q.delete();
            end else begin
                if (f) begin
                    m_rxsh = {m_rxsh[6:0], din};
                    m_bits++;
                    if (m_bits == 8) begin m_rxb = m_rxsh; m_rxv = 1; m_bits = 0; end
                    if (m_sent == 16) m_sent = 0;
                end
                if (r) begin
                    if (m_sent == 0) begin
                        m_q.delete();
                        for (int i = 15; i >= 0; i--) m_q.push_back(m_hold[i]);
                        if (!res_valid) m_drdy = 1;
                    end
                    if (m_q.size() > 0) m_dq = m_q.pop_front();
                    m_sent++;
                end
                if (r || f || old_bits == 0) m_idle = 0;
                else if (m_idle == lim - 1) begin
                    m_idle = 0; m_bits = 0; m_sent = 0; m_q.delete();
                end else m_idle++;
            end
            if (res_valid) begin m_hold = res_data; m_drdy = 0; end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    byte unsigned rxq[$];
    always @(negedge clk) begin
        if (m_live && rst_n) begin
            chk(dout_oe == !cs_n, "R2 dout_oe", dout_oe, !cs_n);
            chk(drdy_n == m_drdy, "R7 drdy_n", drdy_n, m_drdy);
            chk(rx_valid == m_rxv, "R3 rx_valid", rx_valid, m_rxv);
            if (m_rxv) chk(rx_byte == m_rxb, "R4 rx_byte", rx_byte, m_rxb);
            if (!cs_n)
                chk(dout == ((m_sent != 0) ? m_dq : m_drdy), "R5/R6 dout", dout,
                    (m_sent != 0) ? m_dq : m_drdy);
        end
        if (rst_n && rx_valid) rxq.push_back(rx_byte);
    end

    task automatic shift_bits(input logic [7:0] v, input int hi, input int lo,
                              output logic [7:0] got);
        got = '0;
        for (int i = hi; i >= lo; i--) begin
            @(negedge clk); sclk = 1'b1; din = v[i];
            repeat (3) @(negedge clk);
            got[i] = dout;
            sclk = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic select();   @(negedge clk); cs_n = 1'b0; repeat (2) @(negedge clk); endtask
    task automatic deselect(); @(negedge clk); cs_n = 1'b1; repeat (2) @(negedge clk); endtask
    task automatic push_result(input logic [15:0] v);
        @(negedge clk); res_valid = 1'b1; res_data = v;
        @(negedge clk); res_valid = 1'b0;
    endtask
    task automatic expect_rx(input logic [7:0] e, input string tag);
        if (rxq.size() == 0) chk(1'b0, tag, -1, e);
        else begin
            byte unsigned a;
            a = rxq.pop_front();
            chk(a == e, tag, a, e);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] g;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout_oe == 1'b0, "R1 oe after reset", dout_oe, 0);
        chk(drdy_n == 1'b1, "R1 drdy after reset", drdy_n, 1);
        chk(rx_valid == 1'b0, "R1 rx_valid after reset", rx_valid, 0);

        // R7, R6, R5, R3: one result read with a command byte in
        push_result(16'hA5C3);
        chk(drdy_n == 1'b0, "R7 drdy low after result", drdy_n, 0);
        select();
        chk(dout == 1'b0, "R6 dout shows ready", dout, 0);
        shift_bits(8'h3C, 7, 0, g);
        chk(g == 8'hA5, "R5 first byte", g, 8'hA5);
        chk(drdy_n == 1'b1, "R7 drdy released", drdy_n, 1);
        expect_rx(8'h3C, "R3 rx byte");
        shift_bits(8'h81, 7, 0, g);
        chk(g == 8'hC3, "R5 second byte", g, 8'hC3);
        chk(dout == 1'b1, "R6 dout flag after word", dout, 1);
        expect_rx(8'h81, "R4 second rx byte");
        // R4: bytes three and four in the same window repeat the word
        shift_bits(8'hF0, 7, 0, g);
        chk(g == 8'hA5, "R4 third byte restarts word", g, 8'hA5);
        shift_bits(8'h0F, 7, 0, g);
        chk(g == 8'hC3, "R4 fourth byte", g, 8'hC3);
        expect_rx(8'hF0, "R4 third rx byte");
        expect_rx(8'h0F, "R4 fourth rx byte");
        deselect();
        chk(dout_oe == 1'b0, "R2 float when deselected", dout_oe, 0);

        // R8: a result arrives mid-word
        push_result(16'h7E01);
        select();
        shift_bits(8'h00, 7, 0, g);
        chk(g == 8'h7E, "R8 first byte", g, 8'h7E);
        push_result(16'h1234);
        chk(drdy_n == 1'b0, "R8 drdy for new result", drdy_n, 0);
        shift_bits(8'h00, 7, 0, g);
        chk(g == 8'h01, "R8 word not torn", g, 8'h01);
        shift_bits(8'h00, 7, 0, g);
        chk(g == 8'h12, "R8 new word high", g, 8'h12);
        shift_bits(8'h00, 7, 0, g);
        chk(g == 8'h34, "R8 new word low", g, 8'h34);
        rxq.delete();

        // R9: normal limit, pause below and above
        shift_bits(8'h96, 7, 5, g);
        repeat (13000) @(negedge clk);
        shift_bits(8'h96, 4, 0, g);
        expect_rx(8'h96, "R9 short pause keeps byte");
        shift_bits(8'hFF, 7, 5, g);
        repeat (13965) @(negedge clk);
        shift_bits(8'h5A, 7, 0, g);
        expect_rx(8'h5A, "R9 long pause discards partial");
        chk(rxq.size() == 0, "R9 no extra byte", rxq.size(), 0);

        // R10: turbo limit
        @(negedge clk); turbo = 1'b1;
        shift_bits(8'h96, 7, 5, g);
        repeat (20000) @(negedge clk);
        shift_bits(8'h96, 4, 0, g);
        expect_rx(8'h96, "R10 turbo keeps byte past normal limit");
        shift_bits(8'hFF, 7, 5, g);
        repeat (27920) @(negedge clk);
        shift_bits(8'h5A, 7, 0, g);
        expect_rx(8'h5A, "R10 turbo discards after long pause");
        @(negedge clk); turbo = 1'b0;

        // R11: deselect mid-byte
        shift_bits(8'hFF, 7, 4, g);
        deselect();
        select();
        shift_bits(8'hC7, 7, 0, g);
        expect_rx(8'hC7, "R11 deselect restarts framing");
        chk(rxq.size() == 0, "R11 no partial byte", rxq.size(), 0);
        deselect();

        // R12: long pause at a byte boundary keeps the word position
        push_result(16'h2468);
        select();
        shift_bits(8'h00, 7, 0, g);
        chk(g == 8'h24, "R12 first byte", g, 8'h24);
        repeat (14500) @(negedge clk);
        shift_bits(8'h00, 7, 0, g);
        chk(g == 8'h68, "R12 word continues after pause", g, 8'h68);
        deselect();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule